// File: doc/BRIEF.md
# Memory Self-Test Pattern Sequencer

This block tests a small synchronous single-port RAM from the inside of the chip. It drives the RAM's address, write strobe, read strobe and write data. It then compares each returned word against the value that word should hold. A one-cycle pulse on `start` launches a fixed run of six test phases. When the run ends, `done` rises. `fail` shows whether any comparison missed. `fail_addr` and `fail_phase` hold the location and phase of the first miss.

A cell value of "one" means an all-ones word and "zero" means an all-zeros word. The solid phases fill the whole array with one value and then read it all back. The walking phases place one test cell in a background of the opposite value. With the cell in place, every address is read, and then the cell is put back to the background value. Each address in turn serves as the test cell. The galloping phases also use a background of the opposite value. For each test cell, every other address is read in alternation with the test cell itself. This exposes faults that depend on the order of reads.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset, `done` and `fail` are 0 and neither `mem_we` nor `mem_re` is asserted until a start is accepted.
- R2: An accepted start runs the phases in a fixed order, with these codes: 0 solid zeros, 1 solid ones, 2 walking ones, 3 walking zeros, 4 galloping ones, 5 galloping zeros. The first memory access comes in the cycle after `start` is sampled, and there is one access per cycle with no gap between phases.
- R3: A solid phase writes its value to addresses 0 up to DEPTH-1, then reads addresses 0 up to DEPTH-1 and expects that value at each one.
- R4: A walking phase first fills the array with the background value. Then, for each test address b in ascending order, it writes the complement word at b. Next it reads every address in ascending order, expecting the complement at b and the background value elsewhere. Finally it writes the background value back to b.
- R5: A galloping phase first fills the array with the background value. Then, for each test address b in ascending order, it writes the complement word at b. Next, for each address a other than b, in ascending order, it reads a (expecting the background value) and then reads b (expecting the complement). Finally it writes the background value back to b.
- R6: Read data is compared in the cycle after the read is issued. `fail` therefore rises two cycles after the first failing read's address was on the port.
- R7: The first miss sets `fail` and captures the failing address and phase code. The run still goes to its full length, and later misses do not change the captured values.
- R8: `done` rises in the cycle after the last access of phase 5. It stays high, with no memory access, until the next accepted start. A `start` pulse while a run is in progress has no effect.
- R9: An accepted start clears `done`, `fail`, `fail_addr` and `fail_phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only while no run is in progress |
| done | output | 1 | Run finished; held until next start |
| fail | output | 1 | At least one read mismatched |
| fail_addr | output | ADDR_W | Address of the first mismatching read |
| fail_phase | output | 3 | Phase code of the first mismatch |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after `mem_re` |

## Verification
Access k of a run appears on the RAM port k+1 cycles after the edge that samples `start`. The bench builds the full access list in advance and compares the port against the matching entry in each of those cycles. `done` is due one cycle after the last entry, and it is checked in that cycle. A miss on the read issued in cycle k must show up on `fail` in cycle k+2. The bench finds the first failing read by running its own fault model over the access list. It then records the first cycle in which `fail` is high and compares the two.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        PH_ZERO  = 3'd0,
        PH_ONES  = 3'd1,
        PH_WALK1 = 3'd2,
        PH_WALK0 = 3'd3,
        PH_GAL1  = 3'd4,
        PH_GAL0  = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SOLID_RD,
        ST_SET,
        ST_SCAN,
        ST_GAL_A,
        ST_GAL_B,
        ST_RESTORE
    } seq_st_e;

    // Background word is all ones for these phases.
    function automatic logic bg_is_ones(phase_e ph);
        return (ph == PH_ONES) || (ph == PH_WALK0) || (ph == PH_GAL0);
    endfunction

    function automatic logic is_solid(phase_e ph);
        return (ph == PH_ZERO) || (ph == PH_ONES);
    endfunction

    function automatic logic is_walk(phase_e ph);
        return (ph == PH_WALK1) || (ph == PH_WALK0);
    endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              op_we,
    output logic              op_re,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output phase_e            op_phase,
    output logic              finish
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    seq_st_e           st_q, st_d;
    phase_e            ph_q, ph_d;
    logic [ADDR_W-1:0] a_q, a_d, b_q, b_d;
    logic [DATA_W-1:0] bg_w, tst_w;
    logic [ADDR_W-1:0] a_inc, last_a, first_a;
    logic              phase_end;

    assign bg_w    = bg_is_ones(ph_q) ? '1 : '0;
    assign tst_w   = ~bg_w;
    assign a_inc   = a_q + 1'b1;
    assign last_a  = (b_q == LAST) ? LAST - 1'b1 : LAST;
    assign first_a = (b_q == '0) ? {{(ADDR_W-1){1'b0}}, 1'b1} : '0;
    assign busy    = (st_q != ST_IDLE);
    assign op_phase = ph_q;

    always_comb begin
        st_d      = st_q;
        ph_d      = ph_q;
        a_d       = a_q;
        b_d       = b_q;
        phase_end = 1'b0;
        finish    = 1'b0;
        op_we     = 1'b0;
        op_re     = 1'b0;
        op_addr   = a_q;
        op_data   = bg_w;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d = ST_FILL;
                    ph_d = PH_ZERO;
                    a_d  = '0;
                    b_d  = '0;
                end
            end
            ST_FILL: begin
                op_we = 1'b1;
                if (a_q == LAST) begin
                    a_d  = '0;
                    b_d  = '0;
                    st_d = is_solid(ph_q) ? ST_SOLID_RD : ST_SET;
                end else begin
                    a_d = a_inc;
                end
            end
            ST_SOLID_RD: begin
                op_re = 1'b1;
                if (a_q == LAST) phase_end = 1'b1;
                else             a_d = a_inc;
            end
            ST_SET: begin
                op_we   = 1'b1;
                op_addr = b_q;
                op_data = tst_w;
                if (is_walk(ph_q)) begin
                    st_d = ST_SCAN;
                    a_d  = '0;
                end else begin
                    st_d = ST_GAL_A;
                    a_d  = first_a;
                end
            end
            ST_SCAN: begin
                op_re   = 1'b1;
                op_data = (a_q == b_q) ? tst_w : bg_w;
                if (a_q == LAST) st_d = ST_RESTORE;
                else             a_d  = a_inc;
            end
            ST_GAL_A: begin
                op_re = 1'b1;
                st_d  = ST_GAL_B;
            end
            ST_GAL_B: begin
                op_re   = 1'b1;
                op_addr = b_q;
                op_data = tst_w;
                if (a_q == last_a) begin
                    st_d = ST_RESTORE;
                end else begin
                    st_d = ST_GAL_A;
                    a_d  = (a_inc == b_q) ? a_q + 2'd2 : a_inc;
                end
            end
            ST_RESTORE: begin
                op_we   = 1'b1;
                op_addr = b_q;
                if (b_q == LAST) begin
                    phase_end = 1'b1;
                end else begin
                    b_d  = b_q + 1'b1;
                    st_d = ST_SET;
                end
            end
            default: st_d = ST_IDLE;
        endcase

        if (phase_end) begin
            a_d = '0;
            b_d = '0;
            if (ph_q == PH_GAL0) begin
                st_d   = ST_IDLE;
                finish = 1'b1;
            end else begin
                st_d = ST_FILL;
                ph_d = phase_e'(ph_q + 3'd1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            ph_q <= PH_ZERO;
            a_q  <= '0;
            b_q  <= '0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
            a_q  <= a_d;
            b_q  <= b_d;
        end
    end

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_exp,
    input  phase_e            rd_phase,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_phase
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp;
        phase_e            ph;
    } pend_t;

    pend_t pend_q;
    logic  miss;

    assign miss = pend_q.vld && (rd_data != pend_q.exp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q.vld  <= rd_issue;
            pend_q.addr <= rd_addr;
            pend_q.exp  <= rd_exp;
            pend_q.ph   <= rd_phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail       <= 1'b0;
            fail_addr  <= '0;
            fail_phase <= '0;
        end else if (miss && !fail) begin
            fail       <= 1'b1;
            fail_addr  <= pend_q.addr;
            fail_phase <= pend_q.ph;
        end
    end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_phase,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              busy, finish, accept;
    logic [DATA_W-1:0] op_data;
    phase_e            op_phase;

    assign accept    = start && !busy;
    assign mem_wdata = mem_we ? op_data : '0;

    mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .op_we    (mem_we),
        .op_re    (mem_re),
        .op_addr  (mem_addr),
        .op_data  (op_data),
        .op_phase (op_phase),
        .finish   (finish)
    );

    mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .rd_issue   (mem_re),
        .rd_addr    (mem_addr),
        .rd_exp     (op_data),
        .rd_phase   (op_phase),
        .rd_data    (mem_rdata),
        .fail       (fail),
        .fail_addr  (fail_addr),
        .fail_phase (fail_phase)
    );

    always_ff @(posedge clk) begin
        if (rst || accept) done <= 1'b0;
        else if (finish)   done <= 1'b1;
    end

endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [2:0]        fail_phase,
    input logic              mem_we,
    input logic              mem_re
);
    a_r1_one_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_we && !mem_re));

    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    a_r7_first_kept: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_phase)));

    a_r2_phase_code: assert property (@(posedge clk) disable iff (rst)
        fail |-> (fail_phase <= 3'd5));

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> $past(mem_re, 2));

endmodule

bind mbist_ctrl mbist_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .fail       (fail),
    .fail_addr  (fail_addr),
    .fail_phase (fail_phase),
    .mem_we     (mem_we),
    .mem_re     (mem_re)
);

// File: tb/mbist_ctrl_test.sv
`timescale 1ns/1ps
module mbist_ctrl_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        bit          we;
        int          addr;
        logic [DW-1:0] data;
        int          ph;
    } op_t;

    logic          clk = 0;
    logic          rst = 1;
    logic          start = 0;
    logic          done, fail;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [2:0]    fail_phase;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_wdata, mem_rdata;

    int  n_chk = 0, n_bad = 0;
    int  fmode = 0;
    bit  ended = 0;
    op_t ops[$];

    always #2.5 clk = ~clk;

    mbist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_phase(fail_phase), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // RAM with injectable faults, one-cycle read latency
    logic [DW-1:0] ram [DEPTH];
    int            prev_rd = -1;
    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            if (fmode == 3 && mem_addr == 3 && mem_wdata == '1) ram[12] <= '1;
        end else if (mem_re) begin
            logic [DW-1:0] r;
            r = ram[mem_addr];
            if (fmode == 1 && mem_addr == 5) r[0] = 1'b1;
            if (fmode == 2 && mem_addr == 9) r[7] = 1'b0;
            if (fmode == 4 && mem_addr == 2 && prev_rd == 10) r = ~r;
            prev_rd = int'(mem_addr);
            mem_rdata <= r;
        end
    end

    task automatic chk(bit ok, string req, string what, longint got, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic push(bit we, int a, logic [DW-1:0] d, int ph);
        op_t o;
        o.we = we; o.addr = a; o.data = d; o.ph = ph;
        ops.push_back(o);
    endtask

    task automatic build();
        for (int ph = 0; ph < 6; ph++) begin
            logic [DW-1:0] bg, tv;
            bg = (ph == 1 || ph == 3 || ph == 5) ? '1 : '0;
            tv = ~bg;
            for (int a = 0; a < DEPTH; a++) push(1, a, bg, ph);
            if (ph < 2) begin
                for (int a = 0; a < DEPTH; a++) push(0, a, bg, ph);
            end else begin
                for (int b = 0; b < DEPTH; b++) begin
                    push(1, b, tv, ph);
                    for (int a = 0; a < DEPTH; a++) begin
                        if (ph < 4) push(0, a, (a == b) ? tv : bg, ph);
                        else if (a != b) begin
                            push(0, a, bg, ph);
                            push(0, b, tv, ph);
                        end
                    end
                    push(1, b, bg, ph);
                end
            end
        end
    endtask

    task automatic predict(int fm, output bit ef, output int ea, output int ep, output int eidx);
        logic [DW-1:0] m [DEPTH];
        int prv = -1;
        ef = 0; ea = 0; ep = 0; eidx = -1;
        foreach (ops[i]) begin
            if (ops[i].we) begin
                m[ops[i].addr] = ops[i].data;
                if (fm == 3 && ops[i].addr == 3 && ops[i].data == '1) m[12] = '1;
            end else begin
                logic [DW-1:0] r;
                r = m[ops[i].addr];
                if (fm == 1 && ops[i].addr == 5) r[0] = 1'b1;
                if (fm == 2 && ops[i].addr == 9) r[7] = 1'b0;
                if (fm == 4 && ops[i].addr == 2 && prv == 10) r = ~r;
                prv = ops[i].addr;
                if (!ef && r != ops[i].data) begin
                    ef = 1; ea = ops[i].addr; ep = ops[i].ph; eidx = i;
                end
            end
        end
    endtask

    task automatic run(int fm, bit poke);
        bit ef; int ea, ep, eidx, seen;
        fmode = fm;
        predict(fm, ef, ea, ep, eidx);
        seen = -1;
        @(negedge clk) start = 1;
        @(posedge clk);
        foreach (ops[i]) begin
            string tag;
            @(negedge clk);
            if (i == 0) begin
                start = 0;
                chk(!fail && !done, "R9", "clear on start", {fail, done}, 0);
            end
            if (poke) start = (i == 100);
            tag = (ops[i].ph < 2) ? "R2 R3" : (ops[i].ph < 4) ? "R2 R4" : "R2 R5";
            chk({mem_we, mem_re, mem_addr, mem_wdata, done} ==
                {ops[i].we, !ops[i].we, AW'(ops[i].addr),
                 ops[i].we ? ops[i].data : DW'(0), 1'b0},
                tag, $sformatf("access %0d", i),
                {mem_we, mem_re, mem_addr, mem_wdata, done},
                {ops[i].we, !ops[i].we, AW'(ops[i].addr),
                 ops[i].we ? ops[i].data : DW'(0), 1'b0});
            if (fail && seen < 0) seen = i;
        end
        @(negedge clk);
        if (fail && seen < 0) seen = ops.size();
        chk(done, "R8", "done after last access", done, 1);
        chk(fail == ef, "R7", "fail flag", fail, ef);
        if (ef) begin
            chk(fail_addr == AW'(ea), "R7", "fail_addr", fail_addr, ea);
            chk(fail_phase == 3'(ep), "R7", "fail_phase", fail_phase, ep);
            chk(seen == eidx + 2, "R6", "fail latency", seen, eidx + 2);
        end
        repeat (3) @(negedge clk);
        chk(done && !mem_we && !mem_re, "R8", "done held idle", {done, mem_we, mem_re}, 3'b100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        build();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        repeat (2) @(negedge clk);
        chk(!done && !fail && !mem_we && !mem_re, "R1", "reset state",
            {done, fail, mem_we, mem_re}, 0);
        run(0, 1);   // clean memory, plus ignored start mid-run (R8)
        run(1, 0);   // stuck bit high, caught in solid zeros
        run(0, 0);   // R9: restart clears earlier fail
        run(2, 0);   // stuck bit low, caught in solid ones
        run(3, 0);   // write coupling, caught by walking ones
        run(4, 0);   // read-order fault, caught by galloping
        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule